// File: doc/BRIEF.md
# Exposure Controller for an Image-Sensor Timing Generator

This block decides, line by line, when a sensor's accumulated charge is swept away, when it is read out, and whether an exposure is currently running. It sees two single-cycle strobes: a line strobe that marks each line and a frame strobe that restarts the line count. From these strobes it produces three outputs: a sweep request for the line just started, a readout strobe, and an exposure-in-progress flag.

Two programmed values set the exposure. The fast value is a count of sweep pulses. They are issued on the line strobes that follow each readout, so exposure begins only after the last sweep. The slow value is a count of readout slots to skip, so one exposure can cover several whole frames. Exposure is therefore the skipped frames plus the part of the period between readouts that is not swept. A separate frame-sweep mode moves the readout slot later in the frame and ignores the skip count.

Software writes all values into a shadow set through a parallel bus with a load strobe. The values are copied into use only at a readout that actually takes place. A readout slot that is suppressed leaves the values in use unchanged. The reset input is asynchronous, active low, and is released synchronously inside the block.

Top module: `exp_shutter_ctrl`

## Requirements
- R1: After reset all three outputs are low. The fast value, the slow value, the mode, the disable bit and the skip counter are all zero. So the first readout slot after reset produces a readout with no sweep pulses after it.
- R2: A frame strobe sets the line count to zero. Each later line strobe adds one, and the count saturates. A line strobe in the same cycle as a frame strobe is not counted and has no other effect. The readout slot is the line strobe that brings the count to 8 in normal mode (mode bit 0), or to 42 in frame-sweep mode (mode bit 1).
- R3: A readout slot with a skip counter of zero produces a `readout_o` pulse exactly one cycle long, in the cycle after the slot's line strobe.
- R4: With slow value N in use, each readout is followed by N suppressed readout slots before the next readout.
- R5: In frame-sweep mode the slow value is ignored, so every slot at line 42 reads out. A frame shorter than 42 lines has no readout.
- R6: After each readout, the next F line strobes each give a one-cycle `sweep_o` pulse in the following cycle, where F is the fast value. F = 0 gives no pulses. The pulses stop at the next readout, so a large F sweeps every line until then.
- R7: `exposing_o` is high when all three conditions hold: a readout has occurred since reset, the sweep pulses owed since the last readout are all issued, and the disable bit in use is 0. It rises together with the last sweep pulse, or together with the readout when F = 0.
- R8: The exposure-disable bit (1 forces `exposing_o` low) takes effect only at a readout. Loading it between readouts leaves `exposing_o` unchanged until the next readout.
- R9: A load writes the shadow set only. The shadow set is copied into use only at a readout that takes place. A value loaded in the same cycle as a readout slot waits for the following readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hr_i | input | 1 | Line strobe, one cycle per line |
| fr_i | input | 1 | Frame strobe, one cycle per frame |
| cfg_ld_i | input | 1 | Load strobe for the shadow set |
| cfg_fast_i | input | 10 | Sweep pulses issued after each readout |
| cfg_slow_i | input | 5 | Readout slots skipped between readouts |
| cfg_expdis_i | input | 1 | 1 forces the exposure flag low |
| cfg_mode_i | input | 1 | 0 normal (slot at line 8), 1 frame-sweep (slot at line 42) |
| sweep_o | output | 1 | Sweep request for the line just strobed |
| readout_o | output | 1 | Readout strobe |
| exposing_o | output | 1 | Exposure in progress |

## Verification
A wrong skip counter shows up at the next readout slot as a readout that is missing or extra. That slot comes within one frame. A wrong sweep counter shows up within the same period between readouts: the number of sweep pulses is wrong, or `exposing_o` rises on the wrong line. A shadow copy taken at the wrong point is only visible at the readout after it. For that reason every scenario runs at least one more period after its values are settled, and counts the readouts and sweeps against values computed from the frame length and the programmed counts.

// File: rtl/exp_shutter_pkg.sv
package exp_shutter_pkg;
  typedef enum logic {
    RD_NORMAL      = 1'b0,
    RD_FRAME_SWEEP = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/exp_line_cnt.sv
module exp_line_cnt
  import exp_shutter_pkg::*;
#(
  parameter int LC_W    = 6,
  parameter int RD_NORM = 8,
  parameter int RD_FS   = 42
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hr_i,
  input  logic     fr_i,
  input  rd_mode_e mode_i,
  output logic     slot_o
);
  localparam logic [LC_W-1:0] LC_MAX  = '1;
  localparam logic [LC_W-1:0] SLOT_NM = LC_W'(RD_NORM);
  localparam logic [LC_W-1:0] SLOT_FS = LC_W'(RD_FS);

  logic [LC_W-1:0] lc_q, lc_d, lc_inc, slot_line;
  logic            lc_en;

  // next-state: a frame strobe wins over a coincident line strobe
  always_comb begin
    lc_inc    = lc_q + 1'b1;
    lc_en     = fr_i | (hr_i & (lc_q != LC_MAX));
    lc_d      = fr_i ? '0 : lc_inc;
    slot_line = (mode_i == RD_FRAME_SWEEP) ? SLOT_FS : SLOT_NM;
    slot_o    = hr_i & ~fr_i & (lc_inc == slot_line) & (lc_q != LC_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0;
    end else if (lc_en) begin
      lc_q <= lc_d;
    end
  end
endmodule

// File: rtl/exp_cfg_regs.sv
module exp_cfg_regs
  import exp_shutter_pkg::*;
#(
  parameter int FAST_W = 10,
  parameter int SLOW_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [FAST_W-1:0] fast_i,
  input  logic [SLOW_W-1:0] slow_i,
  input  logic              dis_i,
  input  rd_mode_e          mode_i,
  input  logic              upd_i,
  output logic [FAST_W-1:0] sh_fast_o,
  output logic [SLOW_W-1:0] sh_slow_o,
  output logic              sh_dis_o,
  output rd_mode_e          sh_mode_o,
  output logic              act_dis_o,
  output rd_mode_e          act_mode_o
);
  // shadow set: written by the load strobe only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_fast_o <= '0;
      sh_slow_o <= '0;
      sh_dis_o  <= 1'b0;
      sh_mode_o <= RD_NORMAL;
    end else if (ld_i) begin
      sh_fast_o <= fast_i;
      sh_slow_o <= slow_i;
      sh_dis_o  <= dis_i;
      sh_mode_o <= mode_i;
    end
  end

  // in-use copies of the bits not held in a counter; copied at a readout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dis_o  <= 1'b0;
      act_mode_o <= RD_NORMAL;
    end else if (upd_i) begin
      act_dis_o  <= sh_dis_o;
      act_mode_o <= sh_mode_o;
    end
  end
endmodule

// File: rtl/exp_sweep_ctrl.sv
module exp_sweep_ctrl
  import exp_shutter_pkg::*;
#(
  parameter int FAST_W = 10,
  parameter int SLOW_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hr_i,
  input  logic              fr_i,
  input  logic              slot_i,
  input  rd_mode_e          act_mode_i,
  input  logic              act_dis_i,
  input  logic [FAST_W-1:0] sh_fast_i,
  input  logic [SLOW_W-1:0] sh_slow_i,
  input  logic              sh_dis_i,
  input  rd_mode_e          sh_mode_i,
  output logic              due_o,
  output logic              sweep_o,
  output logic              readout_o,
  output logic              exposing_o
);
  logic [SLOW_W-1:0] skip_q, skip_d;
  logic [FAST_W-1:0] sc_q, sc_d, sc_nx;
  logic              skip_en, sc_en;
  logic              armed_q, armed_nx;
  logic              sweep_now, dis_nx, exp_d;

  always_comb begin
    due_o     = slot_i & ((act_mode_i == RD_FRAME_SWEEP) | (skip_q == '0));
    sweep_now = hr_i & ~fr_i & ~due_o & (sc_q != '0);

    skip_en = slot_i;
    if (due_o) begin
      skip_d = (sh_mode_i == RD_FRAME_SWEEP) ? '0 : sh_slow_i;
    end else begin
      skip_d = skip_q - 1'b1;
    end

    sc_en = due_o | sweep_now;
    sc_d  = due_o ? sh_fast_i : (sc_q - 1'b1);
    sc_nx = sc_en ? sc_d : sc_q;

    armed_nx = armed_q | due_o;
    dis_nx   = due_o ? sh_dis_i : act_dis_i;
    exp_d    = armed_nx & (sc_nx == '0) & ~dis_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
    end else if (skip_en) begin
      skip_q <= skip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
    end else if (sc_en) begin
      sc_q <= sc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      sweep_o    <= 1'b0;
      readout_o  <= 1'b0;
      exposing_o <= 1'b0;
    end else begin
      armed_q    <= armed_nx;
      sweep_o    <= sweep_now;
      readout_o  <= due_o;
      exposing_o <= exp_d;
    end
  end
endmodule

// File: rtl/exp_shutter_ctrl.sv
module exp_shutter_ctrl
  import exp_shutter_pkg::*;
#(
  parameter int FAST_W       = 10,
  parameter int SLOW_W       = 5,
  parameter int RD_LINE_NORM = 8,
  parameter int RD_LINE_FS   = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hr_i,
  input  logic              fr_i,
  input  logic              cfg_ld_i,
  input  logic [FAST_W-1:0] cfg_fast_i,
  input  logic [SLOW_W-1:0] cfg_slow_i,
  input  logic              cfg_expdis_i,
  input  logic              cfg_mode_i,
  output logic              sweep_o,
  output logic              readout_o,
  output logic              exposing_o
);
  localparam int RD_MAX = (RD_LINE_FS > RD_LINE_NORM) ? RD_LINE_FS : RD_LINE_NORM;
  localparam int LC_W   = $clog2(RD_MAX + 2);

  logic [1:0]        rst_sync;
  logic              rst_q;
  logic              slot, due;
  logic [FAST_W-1:0] sh_fast;
  logic [SLOW_W-1:0] sh_slow;
  logic              sh_dis, act_dis;
  rd_mode_e          sh_mode, act_mode, ld_mode;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q   = rst_sync[1];
  assign ld_mode = rd_mode_e'(cfg_mode_i);

  exp_line_cnt #(
    .LC_W    (LC_W),
    .RD_NORM (RD_LINE_NORM),
    .RD_FS   (RD_LINE_FS)
  ) u_lines (
    .clk    (clk),
    .rst_n  (rst_q),
    .hr_i   (hr_i),
    .fr_i   (fr_i),
    .mode_i (act_mode),
    .slot_o (slot)
  );

  exp_cfg_regs #(
    .FAST_W (FAST_W),
    .SLOW_W (SLOW_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_q),
    .ld_i       (cfg_ld_i),
    .fast_i     (cfg_fast_i),
    .slow_i     (cfg_slow_i),
    .dis_i      (cfg_expdis_i),
    .mode_i     (ld_mode),
    .upd_i      (due),
    .sh_fast_o  (sh_fast),
    .sh_slow_o  (sh_slow),
    .sh_dis_o   (sh_dis),
    .sh_mode_o  (sh_mode),
    .act_dis_o  (act_dis),
    .act_mode_o (act_mode)
  );

  exp_sweep_ctrl #(
    .FAST_W (FAST_W),
    .SLOW_W (SLOW_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q),
    .hr_i       (hr_i),
    .fr_i       (fr_i),
    .slot_i     (slot),
    .act_mode_i (act_mode),
    .act_dis_i  (act_dis),
    .sh_fast_i  (sh_fast),
    .sh_slow_i  (sh_slow),
    .sh_dis_i   (sh_dis),
    .sh_mode_i  (sh_mode),
    .due_o      (due),
    .sweep_o    (sweep_o),
    .readout_o  (readout_o),
    .exposing_o (exposing_o)
  );
endmodule

// File: rtl/exp_shutter_chk.sv
module exp_shutter_chk (
  input logic clk,
  input logic rst_q,
  input logic hr_i,
  input logic fr_i,
  input logic sweep_o,
  input logic readout_o,
  input logic exposing_o
);
  // R3: a readout pulse follows a line strobe that had no frame strobe with it
  p_readout_from_line_r3: assert property (@(posedge clk) disable iff (!rst_q)
    readout_o |-> ($past(hr_i) && !$past(fr_i)));

  // R3: a readout pulse lasts one cycle
  p_readout_single_r3: assert property (@(posedge clk) disable iff (!rst_q)
    readout_o |=> !readout_o);

  // R2, R6: a sweep needs an uncounted-free line strobe one cycle earlier
  p_sweep_from_line_r6: assert property (@(posedge clk) disable iff (!rst_q)
    sweep_o |-> ($past(hr_i) && !$past(fr_i)));

  // R6: the readout slot is never also swept
  p_no_sweep_at_readout_r6: assert property (@(posedge clk) disable iff (!rst_q)
    readout_o |-> !sweep_o);

  // R7: exposure starts with the last sweep or with a readout
  p_expo_start_r7: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(exposing_o) |-> (sweep_o || readout_o));

  // R8: exposure ends only at a readout
  p_expo_end_r8: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(exposing_o) |-> readout_o);
endmodule

bind exp_shutter_ctrl exp_shutter_chk u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .hr_i       (hr_i),
  .fr_i       (fr_i),
  .sweep_o    (sweep_o),
  .readout_o  (readout_o),
  .exposing_o (exposing_o)
);

// File: tb/sim_exp_shutter_ctrl.sv
module sim_exp_shutter_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RD_N = 8;
  localparam int RD_F = 42;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hr = 1'b0, fr = 1'b0, ld = 1'b0;
  logic [9:0] fast_v = '0;
  logic [4:0] slow_v = '0;
  logic       dis_v = 1'b0, mode_v = 1'b0;
  logic       sweep, ro, expo;

  exp_shutter_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .hr_i (hr), .fr_i (fr),
    .cfg_ld_i (ld), .cfg_fast_i (fast_v), .cfg_slow_i (slow_v),
    .cfg_expdis_i (dis_v), .cfg_mode_i (mode_v),
    .sweep_o (sweep), .readout_o (ro), .exposing_o (expo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cnt_ro = 0, cnt_sw = 0;
  bit done = 0;
  logic g_ro, g_sw, g_exp;

  // model of the requirements
  int m_lc, m_skip, m_sc, sh_fast, sh_slow;
  bit m_armed, m_mode, m_dis, sh_dis, sh_mode;
  bit e_sw, e_ro, e_exp;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_lc = 0; m_skip = 0; m_sc = 0; sh_fast = 0; sh_slow = 0;
    m_armed = 0; m_mode = 0; m_dis = 0; sh_dis = 0; sh_mode = 0;
    e_exp = 0;
  endtask

  task automatic ev(bit h, bit f, bit l, int fv, int sv, bit dv, bit mv, string tag);
    int  rdl;
    bit  slot, due;
    @(negedge clk);
    hr = h; fr = f; ld = l;
    if (l) begin fast_v = 10'(fv); slow_v = 5'(sv); dis_v = dv; mode_v = mv; end
    rdl = m_mode ? RD_F : RD_N;
    slot = 0;
    if (f) m_lc = 0;
    else if (h) begin
      slot = (m_lc + 1 == rdl) && (m_lc < 63);
      if (m_lc < 63) m_lc++;
    end
    due  = slot && (m_mode || m_skip == 0);
    e_sw = h && !f && !due && (m_sc != 0);
    if (slot) m_skip = due ? (sh_mode ? 0 : sh_slow) : m_skip - 1;
    if (due) begin
      m_sc = sh_fast; m_mode = sh_mode; m_dis = sh_dis; m_armed = 1;
    end else if (e_sw) m_sc--;
    if (l) begin sh_fast = fv; sh_slow = sv; sh_dis = dv; sh_mode = mv; end
    e_ro  = due;
    e_exp = m_armed && (m_sc == 0) && !m_dis;
    @(negedge clk);
    hr = 0; fr = 0; ld = 0;
    g_ro = ro; g_sw = sweep; g_exp = expo;
    cnt_ro += int'(ro); cnt_sw += int'(sweep);
    chk($sformatf("%s readout", tag), ro, e_ro);
    chk($sformatf("%s sweep", tag), sweep, e_sw);
    chk($sformatf("%s exposing", tag), expo, e_exp);
    @(negedge clk);
    chk($sformatf("%s R3 single readout cycle", tag), ro, 0);
    chk($sformatf("%s R6 single sweep cycle", tag), sweep, 0);
    chk($sformatf("%s R7 exposing held", tag), expo, e_exp);
  endtask

  task automatic line(string tag);
    ev(1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic frame(int n, string tag);
    ev(0, 1, 0, 0, 0, 0, 0, tag);
    for (int i = 0; i < n; i++) line(tag);
  endtask

  task automatic load(int fv, int sv, bit dv, bit mv, string tag);
    ev(0, 0, 1, fv, sv, dv, mv, tag);
  endtask

  task automatic settle(int n, string tag);
    int r0;
    r0 = cnt_ro;
    for (int i = 0; i < 40; i++) begin
      frame(n, tag);
      if (cnt_ro != r0) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {29'd0, sweep, ro, expo}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 outputs after release", {29'd0, sweep, ro, expo}, 0);
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1-chain: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int r0, s0, pos, fl[9], sl[5];
    do_reset();

    // R1: first slot after reset reads out, no sweeps follow
    r0 = cnt_ro; s0 = cnt_sw;
    frame(12, "R1 first frame");
    frame(12, "R1 second frame");
    chk("R1 readouts after reset", cnt_ro - r0, 2);
    chk("R1 no sweeps with zero fast value", cnt_sw - s0, 0);

    // R6: sweep counts per period, 12-line frames leave 11 sweepable lines
    fl = '{0, 1, 3, 4, 5, 10, 11, 20, 1023};
    foreach (fl[k]) begin
      load(fl[k], 0, 0, 0, "R6 load");
      frame(12, "R9 apply"); frame(12, "R6 steady");
      r0 = cnt_ro; s0 = cnt_sw;
      repeat (3) frame(12, "R6 measure");
      chk($sformatf("R6 sweeps F=%0d", fl[k]), cnt_sw - s0, 3 * ((fl[k] < 11) ? fl[k] : 11));
      chk($sformatf("R3 readouts F=%0d", fl[k]), cnt_ro - r0, 3);
    end

    // R2: line strobe with frame strobe is not counted, slot at 8th line
    ev(1, 1, 0, 0, 0, 0, 0, "R2 coincident strobes");
    chk("R2 no sweep on coincident strobe", g_sw, 0);
    pos = 0;
    for (int i = 1; i <= 12; i++) begin
      line("R2 count");
      if (g_ro && pos == 0) pos = i;
    end
    chk("R2 readout slot line", pos, RD_N);

    // R7: exposure low while sweeping, high with the last sweep
    load(4, 0, 0, 0, "R7 load");
    frame(12, "R7 apply"); frame(12, "R7 steady");
    ev(0, 1, 0, 0, 0, 0, 0, "R7 frame");
    for (int i = 1; i <= 8; i++) line("R7 to slot");
    chk("R7 low after readout with sweeps owed", g_exp, 0);
    for (int i = 1; i <= 3; i++) line("R7 sweeping");
    chk("R7 still low before last sweep", g_exp, 0);
    line("R7 last sweep");
    chk("R7 high with last sweep", g_exp, 1);

    // R8: disable waits for the readout
    load(4, 0, 1, 0, "R8 load disable");
    chk("R8 exposing unchanged after load", g_exp, 1);
    ev(0, 1, 0, 0, 0, 0, 0, "R8 frame");
    for (int i = 1; i <= 7; i++) line("R8 before slot");
    chk("R8 still high before readout", g_exp, 1);
    line("R8 slot");
    chk("R8 readout", g_ro, 1);
    chk("R8 low at readout", g_exp, 0);
    for (int i = 9; i <= 12; i++) line("R8 rest");
    chk("R8 stays low", g_exp, 0);
    load(4, 0, 0, 0, "R8 clear");
    frame(12, "R8 reenable"); frame(12, "R8 reenable");
    chk("R8 high again", g_exp, 1);

    // R4: skip counts
    sl = '{0, 1, 2, 5, 31};
    foreach (sl[k]) begin
      load(3, sl[k], 0, 0, "R4 load");
      settle(12, "R9 settle");
      frame(12, "R4 settle tail");
      r0 = cnt_ro; s0 = cnt_sw;
      repeat (3 * (sl[k] + 1)) frame(12, "R4 measure");
      chk($sformatf("R4 readouts slow=%0d", sl[k]), cnt_ro - r0, 3);
      chk($sformatf("R6 sweeps slow=%0d", sl[k]), cnt_sw - s0, 9);
    end

    // R9: suppressed slots copy nothing
    load(3, 2, 0, 0, "R9 load");
    settle(12, "R9 settle");
    load(7, 2, 0, 0, "R9 new fast");
    r0 = cnt_ro; s0 = cnt_sw;
    frame(12, "R9 suppressed"); frame(12, "R9 suppressed");
    chk("R9 no readout in suppressed frames", cnt_ro - r0, 0);
    chk("R9 no sweeps in suppressed frames", cnt_sw - s0, 0);
    s0 = cnt_sw;
    frame(12, "R9 readout frame"); frame(12, "R9 next");
    chk("R9 new fast used after readout", cnt_sw - s0, 7);

    // R9: load in the same cycle as the readout slot waits
    load(2, 0, 0, 0, "R9 slow zero");
    settle(12, "R9 settle");
    frame(12, "R9 steady");
    ev(0, 1, 0, 0, 0, 0, 0, "R9 frame");
    for (int i = 1; i <= 7; i++) line("R9 before slot");
    ev(1, 0, 1, 9, 0, 0, 0, "R9 load at slot");
    chk("R9 readout at slot with load", g_ro, 1);
    s0 = cnt_sw;
    for (int i = 9; i <= 12; i++) line("R9 after slot");
    ev(0, 1, 0, 0, 0, 0, 0, "R9 frame");
    for (int i = 1; i <= 7; i++) line("R9 before slot");
    chk("R9 old fast used after same-cycle load", cnt_sw - s0, 2);
    line("R9 slot");
    s0 = cnt_sw;
    for (int i = 9; i <= 12; i++) line("R9 after slot");
    ev(0, 1, 0, 0, 0, 0, 0, "R9 frame");
    for (int i = 1; i <= 7; i++) line("R9 before slot");
    chk("R9 loaded fast used one readout later", cnt_sw - s0, 9);

    // R5: frame-sweep mode, slot at line 42, slow ignored
    load(5, 3, 0, 1, "R5 load");
    settle(50, "R5 settle");
    frame(50, "R5 steady");
    r0 = cnt_ro; s0 = cnt_sw;
    repeat (3) frame(50, "R5 measure");
    chk("R5 readout every frame", cnt_ro - r0, 3);
    chk("R5 sweeps", cnt_sw - s0, 15);
    r0 = cnt_ro;
    frame(30, "R5 short frame");
    chk("R5 no readout before line 42", cnt_ro - r0, 0);
    ev(0, 1, 0, 0, 0, 0, 0, "R5 frame");
    pos = 0;
    for (int i = 1; i <= 45; i++) begin
      line("R5 count");
      if (g_ro && pos == 0) pos = i;
    end
    chk("R5 slot line", pos, RD_F);

    // R1: reset clears skip and values mid-run
    load(9, 5, 0, 0, "R1 preload");
    settle(50, "R1 settle");
    do_reset();
    r0 = cnt_ro; s0 = cnt_sw;
    frame(12, "R1 after reset");
    chk("R1 readout at first slot after reset", cnt_ro - r0, 1);
    chk("R1 no sweeps after reset", cnt_sw - s0, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule